// File: doc/BRIEF.md
# Read-Only Instruction Cache Controller

This block is the controller of a small level-one instruction cache that the core can only read. A fetch request arrives on a valid/ready port. When the line holding the fetch address is present, the controller returns the whole line and its line address to the core on the next cycle. When the line is absent, the controller sends a read-block request toward one of several second-level banks and retires the fetch. It does not allocate a line and does not record the outstanding miss. The request leaves through a fixed-length delay line that models transport time. The bank index is taken from the address bits that sit just above the block offset.

Second-level data comes back as fill responses on a second valid/ready port. A fill for a line that is already present overwrites that line in place. A fill whose set still has an invalid way installs into the lowest-numbered invalid way. In both cases the line becomes Valid and its data goes to the core. When the set is full, the controller holds the response unaccepted. In that cycle it invalidates the way chosen by a per-set round-robin pointer, and it accepts the same response on the next cycle. Every line is either Invalid or Valid; a Valid line is read-only. A response of any kind other than a data fill is consumed and flagged, and the arrays are left untouched.

Top module: `icache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `fetch_ready` is 1, and `ret_valid`, `req_valid` and `rsp_err` are 0.
- R2: A fetch that hits a Valid line drives `ret_valid` high after the accepting edge, with that line's data on `ret_line` and the line address (offset bits cleared) on `ret_addr`. It sends no read-block request.
- R3: A fetch that misses returns nothing to the core. After the transport delay it sends one request whose `req_addr` is the line address with the low OFFS_W bits at 0. It allocates no line, so a later fetch to that line misses again.
- R4: Repeated fetches to the same missing line each send their own request, one per accepted fetch.
- R5: A request accepted on clock edge E appears on `req_valid`, for one cycle, after edge E+REQ_LAT (default 80).
- R6: `req_bank` equals the BANK_W address bits that start at bit OFFS_W of the requested address.
- R7: A fill (`rsp_kind` = 2'b01) whose set has a free way or already holds the line is accepted in the cycle it is offered. After the accepting edge, `ret_valid` is 1 with the fill's data and line address, and later fetches of that line hit.
- R8: A fill for a line that is already present rewrites the same way. It does not occupy a second way, and later fetches return the new data.
- R9: A fill for an absent line into a full set is not accepted in its first cycle. In that cycle the way selected by the set's round-robin pointer is invalidated. The pointer starts at way 0 after reset and advances by one way (wrapping) on each eviction in that set, and the fill is accepted on the next cycle.
- R10: A response with `rsp_kind` other than 2'b01 is accepted at once and dropped. `rsp_err` is 1 for one cycle after the accepting edge, nothing is returned, and no line is installed.
- R11: In a cycle where a fill is being accepted, `fetch_ready` is 0. A fill held for eviction does not lower `fetch_ready`, so a fetch hit proceeds in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Controller accepts the fetch this cycle |
| fetch_addr | input | 16 | Fetch byte address |
| ret_valid | output | 1 | Line returned to core this cycle |
| ret_addr | output | 16 | Line address of the returned line |
| ret_line | output | 32 | Returned line data |
| req_valid | output | 1 | Read-block request delivered |
| req_addr | output | 16 | Requested line address |
| req_bank | output | 2 | Destination second-level bank |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Controller consumes the response this cycle |
| rsp_kind | input | 2 | Response kind, 2'b01 = data fill |
| rsp_addr | input | 16 | Line address of the response |
| rsp_line | input | 32 | Fill data |
| rsp_err | output | 1 | Non-fill response seen |

## Verification
The return port to the core has two sources: a fetch hit and an accepted fill. Both could want it on the same edge. Acceptance of a fill therefore lowers `fetch_ready`, while a fill that is held for eviction leaves the fetch port open. The bench presents a fill into a full set together with a fetch that hits another set in the same cycle. It then expects the hit data on the first edge, with the fill still unaccepted. On the second edge it expects the fill's data, and during that cycle `fetch_ready` must be low.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic {
    LINE_INVALID = 1'b0,
    LINE_VALID   = 1'b1
  } line_state_e;

  localparam logic [1:0] RSP_KIND_FILL = 2'b01;

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
  import icache_pkg::*;
#(
  parameter int SET_W  = 2,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 12,
  parameter int LINE_W = 32,
  parameter int WAY_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup for the fetch port
  input  logic [SET_W-1:0]  a_set,
  input  logic [TAG_W-1:0]  a_tag,
  output logic              a_hit,
  output logic [LINE_W-1:0] a_data,
  // lookup for the response port
  input  logic [SET_W-1:0]  b_set,
  input  logic [TAG_W-1:0]  b_tag,
  output logic              b_present,
  output logic [WAY_W-1:0]  b_way,
  output logic              b_free,
  output logic [WAY_W-1:0]  b_free_way,
  // install
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  // invalidate
  input  logic              inv_en,
  input  logic [SET_W-1:0]  inv_set,
  input  logic [WAY_W-1:0]  inv_way
);

  localparam int SETS = 1 << SET_W;

  line_state_e       st_q   [SETS][WAYS];
  line_state_e       st_d   [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] data_q [SETS][WAYS];

  // fetch-side lookup
  always_comb begin
    a_hit  = 1'b0;
    a_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (st_q[a_set][w] == LINE_VALID && tag_q[a_set][w] == a_tag) begin
        a_hit  = 1'b1;
        a_data = data_q[a_set][w];
      end
    end
  end

  // response-side lookup: presence and lowest free way
  always_comb begin
    b_present  = 1'b0;
    b_way      = '0;
    b_free     = 1'b0;
    b_free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (st_q[b_set][w] == LINE_VALID && tag_q[b_set][w] == b_tag) begin
        b_present = 1'b1;
        b_way     = WAY_W'(w);
      end
      if (st_q[b_set][w] == LINE_INVALID) begin
        b_free     = 1'b1;
        b_free_way = WAY_W'(w);
      end
    end
  end

  // next state of the line states
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        st_d[s][w] = st_q[s][w];
        if (wr_en && wr_set == SET_W'(s) && wr_way == WAY_W'(w)) begin
          st_d[s][w] = LINE_VALID;
        end else if (inv_en && inv_set == SET_W'(s) && inv_way == WAY_W'(w)) begin
          st_d[s][w] = LINE_INVALID;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w] <= LINE_INVALID;
        end
      end
    end else begin
      st_q <= st_d;
    end
  end

  // tag and data arrays: written only on install, not reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      data_q[wr_set][wr_way] <= wr_data;
    end
  end

endmodule

// File: rtl/icache_victim_rr.sv
module icache_victim_rr #(
  parameter int SET_W = 2,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] sel_set,
  input  logic             adv_en,
  output logic [WAY_W-1:0] cur_way
);

  localparam int SETS = 1 << SET_W;

  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] ptr_d [SETS];

  assign cur_way = ptr_q[sel_set];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      ptr_d[s] = ptr_q[s];
      if (adv_en && sel_set == SET_W'(s)) begin
        ptr_d[s] = (ptr_q[s] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
      end
    end else begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/icache_req_delay.sv
module icache_req_delay #(
  parameter int LAT   = 80,
  parameter int PAY_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  output logic [PAY_W-1:0] out_pay
);

  for (genvar k = 0; k < LAT; k++) begin : g_stage
    logic             stg_v;
    logic [PAY_W-1:0] stg_p;
    logic             src_v;
    logic [PAY_W-1:0] src_p;

    if (k == 0) begin : g_head
      assign src_v = in_valid;
      assign src_p = in_pay;
    end else begin : g_body
      assign src_v = g_stage[k-1].stg_v;
      assign src_p = g_stage[k-1].stg_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_v <= 1'b0;
      else        stg_v <= src_v;
    end

    always_ff @(posedge clk) begin
      if (src_v) stg_p <= src_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= g_stage[LAT-1].stg_v;
  end

  always_ff @(posedge clk) begin
    if (g_stage[LAT-1].stg_v) out_pay <= g_stage[LAT-1].stg_p;
  end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFFS_W  = 2,
  parameter int SET_W   = 2,
  parameter int WAYS    = 2,
  parameter int LINE_W  = 32,
  parameter int BANK_W  = 2,
  parameter int REQ_LAT = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              ret_valid,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [LINE_W-1:0] ret_line,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BANK_W-1:0] req_bank,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_kind,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [LINE_W-1:0] rsp_line,
  output logic              rsp_err
);

  localparam int TAG_W = ADDR_W - OFFS_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PAY_W = ADDR_W + BANK_W;

  // address fields
  logic [SET_W-1:0]  f_set, r_set;
  logic [TAG_W-1:0]  f_tag, r_tag;
  logic [ADDR_W-1:0] f_line_addr, r_line_addr;

  assign f_set       = fetch_addr[OFFS_W +: SET_W];
  assign f_tag       = fetch_addr[ADDR_W-1 -: TAG_W];
  assign r_set       = rsp_addr[OFFS_W +: SET_W];
  assign r_tag       = rsp_addr[ADDR_W-1 -: TAG_W];
  assign f_line_addr = {fetch_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
  assign r_line_addr = {rsp_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};

  // array lookups
  logic              a_hit;
  logic [LINE_W-1:0] a_data;
  logic              b_present, b_free;
  logic [WAY_W-1:0]  b_way, b_free_way;
  logic [WAY_W-1:0]  victim_way;

  // control decisions
  logic              is_fill;
  logic              do_install;
  logic              do_evict;
  logic              fetch_go;
  logic              miss_go;
  logic [WAY_W-1:0]  install_way;

  always_comb begin
    is_fill     = (rsp_kind == RSP_KIND_FILL);
    do_install  = rsp_valid && is_fill && (b_present || b_free);
    do_evict    = rsp_valid && is_fill && !b_present && !b_free;
    install_way = b_present ? b_way : b_free_way;
    rsp_ready   = !is_fill || b_present || b_free;
    fetch_ready = !do_install;
    fetch_go    = fetch_valid && fetch_ready;
    miss_go     = fetch_go && !a_hit;
  end

  icache_tag_store #(
    .SET_W  (SET_W),
    .WAYS   (WAYS),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W),
    .WAY_W  (WAY_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_set      (f_set),
    .a_tag      (f_tag),
    .a_hit      (a_hit),
    .a_data     (a_data),
    .b_set      (r_set),
    .b_tag      (r_tag),
    .b_present  (b_present),
    .b_way      (b_way),
    .b_free     (b_free),
    .b_free_way (b_free_way),
    .wr_en      (do_install),
    .wr_set     (r_set),
    .wr_way     (install_way),
    .wr_tag     (r_tag),
    .wr_data    (rsp_line),
    .inv_en     (do_evict),
    .inv_set    (r_set),
    .inv_way    (victim_way)
  );

  icache_victim_rr #(
    .SET_W (SET_W),
    .WAYS  (WAYS),
    .WAY_W (WAY_W)
  ) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_set (r_set),
    .adv_en  (do_evict),
    .cur_way (victim_way)
  );

  // miss request transport
  logic [PAY_W-1:0] miss_pay, out_pay;

  assign miss_pay = {f_line_addr[OFFS_W +: BANK_W], f_line_addr};

  icache_req_delay #(
    .LAT   (REQ_LAT),
    .PAY_W (PAY_W)
  ) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (miss_go),
    .in_pay    (miss_pay),
    .out_valid (req_valid),
    .out_pay   (out_pay)
  );

  assign req_addr = out_pay[ADDR_W-1:0];
  assign req_bank = out_pay[PAY_W-1 -: BANK_W];

  // core return and error flag: next state
  logic              ret_valid_d;
  logic [ADDR_W-1:0] ret_addr_d;
  logic [LINE_W-1:0] ret_line_d;
  logic              rsp_err_d;

  always_comb begin
    ret_valid_d = do_install || (fetch_go && a_hit);
    ret_addr_d  = do_install ? r_line_addr : f_line_addr;
    ret_line_d  = do_install ? rsp_line : a_data;
    rsp_err_d   = rsp_valid && !is_fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      ret_valid <= ret_valid_d;
      rsp_err   <= rsp_err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ret_valid_d) begin
      ret_addr <= ret_addr_d;
      ret_line <= ret_line_d;
    end
  end

endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk
  import icache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFFS_W  = 2,
  parameter int SET_W   = 2,
  parameter int WAYS    = 2,
  parameter int LINE_W  = 32,
  parameter int BANK_W  = 2,
  parameter int REQ_LAT = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              ret_valid,
  input logic [ADDR_W-1:0] ret_addr,
  input logic [LINE_W-1:0] ret_line,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BANK_W-1:0] req_bank,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_kind,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [LINE_W-1:0] rsp_line,
  input logic              rsp_err
);

  AST_FILL_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_kind == RSP_KIND_FILL) |-> !fetch_ready); // R11

  AST_FILL_RETURNS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_kind == RSP_KIND_FILL)
      |=> (ret_valid && ret_line == $past(rsp_line))); // R7

  AST_BAD_KIND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != RSP_KIND_FILL) |-> rsp_ready); // R10

  AST_BAD_KIND_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != RSP_KIND_FILL) |=> rsp_err); // R10

  AST_REQ_BANK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bank == req_addr[OFFS_W +: BANK_W])); // R6

  AST_REQ_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[OFFS_W-1:0] == '0)); // R3

endmodule

bind icache_ctrl icache_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .OFFS_W  (OFFS_W),
  .SET_W   (SET_W),
  .WAYS    (WAYS),
  .LINE_W  (LINE_W),
  .BANK_W  (BANK_W),
  .REQ_LAT (REQ_LAT)
) u_chk (.*);

// File: tb/icache_ctrl_bench.sv
module icache_ctrl_bench;

  localparam int LAT = 80;

  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic        fetch_ready;
  logic [15:0] fetch_addr;
  logic        ret_valid;
  logic [15:0] ret_addr;
  logic [31:0] ret_line;
  logic        req_valid;
  logic [15:0] req_addr;
  logic [1:0]  req_bank;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [1:0]  rsp_kind;
  logic [15:0] rsp_addr;
  logic [31:0] rsp_line;
  logic        rsp_err;

  icache_ctrl #(.REQ_LAT(LAT)) u_icache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_line(ret_line),
    .req_valid(req_valid), .req_addr(req_addr), .req_bank(req_bank),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_addr(rsp_addr), .rsp_line(rsp_line), .rsp_err(rsp_err)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [15:0] log_addr [16];
  logic [1:0]  log_bank [16];
  int          log_cyc  [16];
  int          log_n = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // request monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && req_valid && log_n < 16) begin
      log_addr[log_n] = req_addr;
      log_bank[log_n] = req_bank;
      log_cyc[log_n]  = cyc;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [15:0] a, output bit hit, output logic [31:0] line,
                          output logic [15:0] ra, output int acc);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    hit  = ret_valid;
    line = ret_line;
    ra   = ret_addr;
    acc  = cyc;
  endtask

  task automatic do_fill(input logic [15:0] a, input logic [31:0] d, input logic [1:0] k,
                         output int stalls);
    bit acc;
    acc    = 1'b0;
    stalls = 0;
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_addr  = a;
    rsp_line  = d;
    rsp_kind  = k;
    for (int i = 0; i < 8 && !acc; i++) begin
      #1;
      acc = rsp_ready;
      if (!acc) stalls++;
      @(negedge clk);
    end
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R1 fetch_ready", 32'(fetch_ready), 32'd1);
    chk(ret_valid == 1'b0 && req_valid == 1'b0 && rsp_err == 1'b0, "R1 outputs idle",
        {29'd0, ret_valid, req_valid, rsp_err}, 32'd0);
  endtask

  task automatic t_miss();
    bit hit; logic [31:0] ln; logic [15:0] ra; int e1, e2, e3;
    do_fetch(16'h0A3B, hit, ln, ra, e1);
    chk(!hit, "R3 miss returns nothing", 32'(hit), 32'd0);
    do_fetch(16'h0A39, hit, ln, ra, e2);
    chk(!hit, "R3 no allocation on miss", 32'(hit), 32'd0);
    do_fetch(16'h00F4, hit, ln, ra, e3);
    chk(!hit, "R3 second line miss", 32'(hit), 32'd0);
    repeat (LAT + 3) @(negedge clk);
    chk(log_n == 3, "R4 one request per miss", 32'(log_n), 32'd3);
    chk(log_cyc[0] == e1 + LAT, "R5 first request delay", 32'(log_cyc[0]), 32'(e1 + LAT));
    chk(log_cyc[1] == e2 + LAT, "R5 second request delay", 32'(log_cyc[1]), 32'(e2 + LAT));
    chk(log_addr[0] == 16'h0A38 && log_addr[1] == 16'h0A38, "R3 R4 request line address",
        {log_addr[0], log_addr[1]}, 32'h0A380A38);
    chk(log_bank[0] == 2'd2, "R6 bank of 0A38", 32'(log_bank[0]), 32'd2);
    chk(log_addr[2] == 16'h00F4 && log_bank[2] == 2'd1, "R6 bank of 00F4",
        {14'd0, log_bank[2], log_addr[2]}, {14'd0, 2'd1, 16'h00F4});
  endtask

  task automatic t_fill_free();
    int st; bit hit; logic [31:0] ln; logic [15:0] ra; int e;
    do_fill(16'h0104, 32'h11111111, 2'b01, st);
    chk(st == 0, "R7 fill accepted at once", 32'(st), 32'd0);
    chk(ret_valid && ret_line == 32'h11111111 && ret_addr == 16'h0104, "R7 fill returned",
        ret_line, 32'h11111111);
    do_fetch(16'h0106, hit, ln, ra, e);
    chk(hit && ln == 32'h11111111, "R2 hit data", ln, 32'h11111111);
    chk(ra == 16'h0104, "R2 hit line address", 32'(ra), 32'h0104);
  endtask

  task automatic t_fill_present();
    int st; bit hit; logic [31:0] ln; logic [15:0] ra; int e;
    do_fill(16'h0104, 32'h22222222, 2'b01, st);
    chk(st == 0, "R8 refill accepted", 32'(st), 32'd0);
    do_fill(16'h0204, 32'h33333333, 2'b01, st);
    chk(st == 0, "R8 refill kept one way", 32'(st), 32'd0);
    do_fetch(16'h0104, hit, ln, ra, e);
    chk(hit && ln == 32'h22222222, "R8 new data after refill", ln, 32'h22222222);
  endtask

  task automatic t_overlap();
    int st;
    do_fill(16'h0508, 32'h55555555, 2'b01, st);
    chk(st == 0, "R7 fill other set", 32'(st), 32'd0);
    @(negedge clk);
    rsp_valid   = 1'b1;
    rsp_addr    = 16'h0304;
    rsp_line    = 32'h44444444;
    rsp_kind    = 2'b01;
    fetch_valid = 1'b1;
    fetch_addr  = 16'h0508;
    #1;
    chk(rsp_ready == 1'b0, "R9 full set holds fill", 32'(rsp_ready), 32'd0);
    chk(fetch_ready == 1'b1, "R11 eviction leaves fetch open", 32'(fetch_ready), 32'd1);
    @(negedge clk);
    chk(ret_valid && ret_line == 32'h55555555, "R11 hit during eviction", ret_line, 32'h55555555);
    #1;
    chk(rsp_ready == 1'b1, "R9 fill accepted after eviction", 32'(rsp_ready), 32'd1);
    chk(fetch_ready == 1'b0, "R11 install blocks fetch", 32'(fetch_ready), 32'd0);
    fetch_valid = 1'b0;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(ret_valid && ret_line == 32'h44444444 && ret_addr == 16'h0304, "R7 fill after eviction",
        ret_line, 32'h44444444);
  endtask

  task automatic t_evict();
    int st; bit hit; logic [31:0] ln; logic [15:0] ra; int e;
    do_fetch(16'h0104, hit, ln, ra, e);
    chk(!hit, "R9 way0 victim gone", 32'(hit), 32'd0);
    do_fetch(16'h0204, hit, ln, ra, e);
    chk(hit && ln == 32'h33333333, "R9 way1 survives", ln, 32'h33333333);
    do_fetch(16'h0304, hit, ln, ra, e);
    chk(hit && ln == 32'h44444444, "R9 installed line hits", ln, 32'h44444444);
    do_fill(16'h0104, 32'h66666666, 2'b01, st);
    chk(st == 1, "R9 one eviction cycle", 32'(st), 32'd1);
    do_fetch(16'h0204, hit, ln, ra, e);
    chk(!hit, "R9 pointer advanced to way1", 32'(hit), 32'd0);
    do_fetch(16'h0304, hit, ln, ra, e);
    chk(hit && ln == 32'h44444444, "R9 way0 kept", ln, 32'h44444444);
    do_fetch(16'h0104, hit, ln, ra, e);
    chk(hit && ln == 32'h66666666, "R9 refetched line hits", ln, 32'h66666666);
  endtask

  task automatic t_err();
    int st; bit hit; logic [31:0] ln; logic [15:0] ra; int e;
    do_fill(16'h0C0C, 32'h77777777, 2'b10, st);
    chk(st == 0, "R10 bad kind accepted", 32'(st), 32'd0);
    chk(rsp_err == 1'b1, "R10 error flagged", 32'(rsp_err), 32'd1);
    chk(ret_valid == 1'b0, "R10 nothing returned", 32'(ret_valid), 32'd0);
    do_fetch(16'h0C0C, hit, ln, ra, e);
    chk(!hit, "R10 no install", 32'(hit), 32'd0);
    chk(rsp_err == 1'b0, "R10 flag lasts one cycle", 32'(rsp_err), 32'd0);
  endtask

  task automatic t_final();
    repeat (LAT + 4) @(negedge clk);
    chk(log_n == 6, "R2 hits send no request", 32'(log_n), 32'd6);
    chk(log_addr[5] == 16'h0C0C && log_bank[5] == 2'd3, "R6 bank of 0C0C",
        {14'd0, log_bank[5], log_addr[5]}, {14'd0, 2'd3, 16'h0C0C});
  endtask

  initial begin
    rst_n       = 1'b0;
    fetch_valid = 1'b0;
    fetch_addr  = '0;
    rsp_valid   = 1'b0;
    rsp_kind    = 2'b01;
    rsp_addr    = '0;
    rsp_line    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss();
    t_fill_free();
    t_fill_present();
    t_overlap();
    t_evict();
    t_err();
    t_final();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule